// File: doc/BRIEF.md
# Register Window Controller

This block keeps the bookkeeping for a windowed integer register file. It holds the current window pointer, the four window counters, and a window-state register with an "other" field in bits [5:3] and a "normal" field in bits [2:0]. The counters are the free-window count, the restorable-window count, the clean-window count and the other-context window count. A processor pipeline sends it one operation per cycle: save, restore or return. The block either commits the matching pointer and counter update, or it raises exactly one trap. The trap is a spill, a fill, a clean-window or a misaligned-target trap, and spill and fill traps carry a computed trap type.

Spill and fill traps take their type from the window-state register. The block uses the other field when the other-context count is nonzero and the normal field when it is zero. Trap selection follows a fixed priority. For a return, the fill condition is checked before the alignment of the target address. A state-load port lets privileged code write any of the six state registers. The register storage and the trap vectoring are outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the free count is NWIN-2, the restorable count is 0, the clean count is NWIN-2, the other count is 0, the window-state register is 0, and no trap is flagged.
- R2: A save (op_code 0) with a free count of zero raises a spill trap (trap_kind 0), flagged on trap_valid one cycle after the request.
- R3: The spill and fill trap type is 4 times wstate[5:3] when the other count is nonzero, and 4 times wstate[2:0] when it is zero. Clean-window and misaligned traps report type 0.
- R4: A save with a nonzero free count, where the clean count minus the restorable count is zero modulo 2^PTR_W, raises a clean-window trap (trap_kind 2).
- R5: A save that raises no trap advances the pointer by one modulo NWIN, decrements the free count and increments the restorable count, all visible one cycle later.
- R6: A restore (op_code 1) or return (op_code 2) with a restorable count of zero raises a fill trap (trap_kind 1).
- R7: A restore or return that raises no trap moves the pointer back by one modulo NWIN, increments the free count and decrements the restorable count.
- R8: A return with a restorable count of zero and a misaligned target raises a fill trap, not a misaligned trap.
- R9: A return whose target has nonzero bits [1:0] and whose restorable count is nonzero raises a misaligned trap (trap_kind 3).
- R10: In a cycle that raises a trap, the pointer and all counters keep their values.
- R11: op_code 3 raises no trap and changes nothing. A restore ignores the target address.
- R12: A load with op_valid low writes ld_data into the register picked by ld_sel (0 pointer, 1 free, 2 restorable, 3 clean, 4 other, 5 window-state), visible one cycle later. A load in the same cycle as an operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 2 | 0 save, 1 restore, 2 return, 3 reserved |
| ret_target | input | ADDR_W | Target address of a return |
| ld_valid | input | 1 | State-load strobe |
| ld_sel | input | 3 | Register picked for the load |
| ld_data | input | 6 | Load value, low PTR_W bits used for pointer and counters |
| cwp | output | PTR_W | Current window pointer |
| cansave | output | PTR_W | Free-window count |
| canrestore | output | PTR_W | Restorable-window count |
| cleanwin | output | PTR_W | Clean-window count |
| otherwin | output | PTR_W | Other-context window count |
| wstate | output | 6 | Window-state register |
| trap_valid | output | 1 | A trap was raised by the previous cycle's operation |
| trap_kind | output | 2 | 0 spill, 1 fill, 2 clean-window, 3 misaligned |
| trap_type | output | 5 | Computed trap type |

## Verification
Every result of an operation is due exactly one clock edge after the request. This covers the trap flag, its kind and type, and the committed pointer and counters. A load shows on the register outputs one edge after its strobe. The bench driver records, for each request, the cycle number at which its result is due, along with the expected values from an independent model. The monitor compares on the falling edge of that exact cycle. Back-to-back requests therefore each land in their own cycle, and a result that arrives early or late shows as a mismatch.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETURN  = 2'd2,
    OP_RSVD    = 2'd3
  } win_op_e;

  typedef enum logic [1:0] {
    TK_SPILL    = 2'd0,
    TK_FILL     = 2'd1,
    TK_CLEAN    = 2'd2,
    TK_MISALIGN = 2'd3
  } trap_kind_e;

  typedef enum logic [2:0] {
    LS_CWP   = 3'd0,
    LS_FREE  = 3'd1,
    LS_REST  = 3'd2,
    LS_CLEAN = 3'd3,
    LS_OTHER = 3'd4,
    LS_WST   = 3'd5,
    LS_NONE6 = 3'd6,
    LS_NONE7 = 3'd7
  } ld_sel_e;

  localparam int WS_FIELD_W = 3;
  localparam int WS_W       = 2 * WS_FIELD_W;
  localparam int TT_W       = WS_FIELD_W + 2;

endpackage

// File: rtl/regwin_rst_sync.sv
module regwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int PTR_W = 3
) (
  input  logic                 op_valid,
  input  logic [1:0]           op_code,
  input  logic [1:0]           ret_lo,
  input  logic [PTR_W-1:0]     cwp,
  input  logic [PTR_W-1:0]     cansave,
  input  logic [PTR_W-1:0]     canrestore,
  input  logic [PTR_W-1:0]     cleanwin,
  input  logic [PTR_W-1:0]     otherwin,
  input  logic [WS_W-1:0]      wstate,
  output logic                 commit,
  output logic [PTR_W-1:0]     nxt_cwp,
  output logic [PTR_W-1:0]     nxt_cansave,
  output logic [PTR_W-1:0]     nxt_canrestore,
  output logic                 trap_hit,
  output trap_kind_e           trap_kind,
  output logic [TT_W-1:0]      trap_type
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NWIN - 1);

  win_op_e                op;
  logic [PTR_W-1:0]       clean_gap;
  logic [WS_FIELD_W-1:0]  ws_field;
  logic [TT_W-1:0]        ws_type;
  logic [PTR_W-1:0]       cwp_up;
  logic [PTR_W-1:0]       cwp_dn;

  assign op        = win_op_e'(op_code);
  assign clean_gap = cleanwin - canrestore;
  assign ws_field  = (otherwin != '0) ? wstate[WS_W-1:WS_FIELD_W]
                                      : wstate[WS_FIELD_W-1:0];
  assign ws_type   = {ws_field, 2'b00};
  assign cwp_up    = (cwp == PTR_LAST) ? '0 : cwp + 1'b1;
  assign cwp_dn    = (cwp == '0) ? PTR_LAST : cwp - 1'b1;

  always_comb begin
    commit         = 1'b0;
    trap_hit       = 1'b0;
    trap_kind      = TK_SPILL;
    trap_type      = '0;
    nxt_cwp        = cwp;
    nxt_cansave    = cansave;
    nxt_canrestore = canrestore;
    if (op_valid) begin
      unique case (op)
        OP_SAVE: begin
          if (cansave == '0) begin
            trap_hit  = 1'b1;
            trap_kind = TK_SPILL;
            trap_type = ws_type;
          end else if (clean_gap == '0) begin
            trap_hit  = 1'b1;
            trap_kind = TK_CLEAN;
          end else begin
            commit         = 1'b1;
            nxt_cwp        = cwp_up;
            nxt_cansave    = cansave - 1'b1;
            nxt_canrestore = canrestore + 1'b1;
          end
        end
        OP_RESTORE, OP_RETURN: begin
          if (canrestore == '0) begin
            trap_hit  = 1'b1;
            trap_kind = TK_FILL;
            trap_type = ws_type;
          end else if (op == OP_RETURN && ret_lo != 2'b00) begin
            trap_hit  = 1'b1;
            trap_kind = TK_MISALIGN;
          end else begin
            commit         = 1'b1;
            nxt_cwp        = cwp_dn;
            nxt_cansave    = cansave + 1'b1;
            nxt_canrestore = canrestore - 1'b1;
          end
        end
        default: begin
          commit = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/regwin_state.sv
module regwin_state
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [PTR_W-1:0] nxt_cwp,
  input  logic [PTR_W-1:0] nxt_cansave,
  input  logic [PTR_W-1:0] nxt_canrestore,
  input  logic             ld_en,
  input  logic [2:0]       ld_sel,
  input  logic [WS_W-1:0]  ld_data,
  output logic [PTR_W-1:0] cwp,
  output logic [PTR_W-1:0] cansave,
  output logic [PTR_W-1:0] canrestore,
  output logic [PTR_W-1:0] cleanwin,
  output logic [PTR_W-1:0] otherwin,
  output logic [WS_W-1:0]  wstate
);

  localparam logic [PTR_W-1:0] RST_FREE = PTR_W'(NWIN - 2);

  ld_sel_e          sel;
  logic [PTR_W-1:0] ld_cnt;
  logic             en_cwp, en_free, en_rest, en_clean, en_other, en_wst;
  logic [PTR_W-1:0] d_cwp, d_free, d_rest;

  assign sel    = ld_sel_e'(ld_sel);
  assign ld_cnt = ld_data[PTR_W-1:0];

  always_comb begin
    en_cwp   = commit;
    en_free  = commit;
    en_rest  = commit;
    en_clean = 1'b0;
    en_other = 1'b0;
    en_wst   = 1'b0;
    d_cwp    = nxt_cwp;
    d_free   = nxt_cansave;
    d_rest   = nxt_canrestore;
    if (ld_en) begin
      unique case (sel)
        LS_CWP:   begin en_cwp  = 1'b1; d_cwp  = ld_cnt; end
        LS_FREE:  begin en_free = 1'b1; d_free = ld_cnt; end
        LS_REST:  begin en_rest = 1'b1; d_rest = ld_cnt; end
        LS_CLEAN: en_clean = 1'b1;
        LS_OTHER: en_other = 1'b1;
        LS_WST:   en_wst   = 1'b1;
        default:  en_wst   = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= RST_FREE;
      canrestore <= '0;
      cleanwin   <= RST_FREE;
      otherwin   <= '0;
      wstate     <= '0;
    end else begin
      if (en_cwp)   cwp        <= d_cwp;
      if (en_free)  cansave    <= d_free;
      if (en_rest)  canrestore <= d_rest;
      if (en_clean) cleanwin   <= ld_cnt;
      if (en_other) otherwin   <= ld_cnt;
      if (en_wst)   wstate     <= ld_data;
    end
  end

endmodule

// File: rtl/regwin_trap_reg.sv
module regwin_trap_reg
  import regwin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_hit,
  input  trap_kind_e      kind_d,
  input  logic [TT_W-1:0] type_d,
  output logic            trap_valid,
  output logic [1:0]      trap_kind,
  output logic [TT_W-1:0] trap_type
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_kind  <= 2'b00;
      trap_type  <= '0;
    end else begin
      trap_valid <= trap_hit;
      if (trap_hit) begin
        trap_kind <= kind_d;
        trap_type <= type_d;
      end
    end
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [ADDR_W-1:0] ret_target,
  input  logic              ld_valid,
  input  logic [2:0]        ld_sel,
  input  logic [5:0]        ld_data,
  output logic [PTR_W-1:0]  cwp,
  output logic [PTR_W-1:0]  cansave,
  output logic [PTR_W-1:0]  canrestore,
  output logic [PTR_W-1:0]  cleanwin,
  output logic [PTR_W-1:0]  otherwin,
  output logic [5:0]        wstate,
  output logic              trap_valid,
  output logic [1:0]        trap_kind,
  output logic [4:0]        trap_type
);

  logic             rst_int_n;
  logic             commit;
  logic [PTR_W-1:0] nxt_cwp, nxt_cansave, nxt_canrestore;
  logic             trap_hit;
  trap_kind_e       kind_d;
  logic [TT_W-1:0]  type_d;
  logic             ld_en;
  logic [ADDR_W-3:0] ret_hi_unused;

  assign ret_hi_unused = ret_target[ADDR_W-1:2];
  assign ld_en         = ld_valid & ~op_valid;

  regwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  regwin_decide #(.NWIN(NWIN), .PTR_W(PTR_W)) u_dec (
    .op_valid       (op_valid),
    .op_code        (op_code),
    .ret_lo         (ret_target[1:0]),
    .cwp            (cwp),
    .cansave        (cansave),
    .canrestore     (canrestore),
    .cleanwin       (cleanwin),
    .otherwin       (otherwin),
    .wstate         (wstate),
    .commit         (commit),
    .nxt_cwp        (nxt_cwp),
    .nxt_cansave    (nxt_cansave),
    .nxt_canrestore (nxt_canrestore),
    .trap_hit       (trap_hit),
    .trap_kind      (kind_d),
    .trap_type      (type_d)
  );

  regwin_state #(.NWIN(NWIN), .PTR_W(PTR_W)) u_st (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .commit         (commit),
    .nxt_cwp        (nxt_cwp),
    .nxt_cansave    (nxt_cansave),
    .nxt_canrestore (nxt_canrestore),
    .ld_en          (ld_en),
    .ld_sel         (ld_sel),
    .ld_data        (ld_data),
    .cwp            (cwp),
    .cansave        (cansave),
    .canrestore     (canrestore),
    .cleanwin       (cleanwin),
    .otherwin       (otherwin),
    .wstate         (wstate)
  );

  regwin_trap_reg u_trap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trap_hit   (trap_hit),
    .kind_d     (kind_d),
    .type_d     (type_d),
    .trap_valid (trap_valid),
    .trap_kind  (trap_kind),
    .trap_type  (trap_type)
  );

endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
  parameter int NWIN  = 8,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_code,
  input logic [1:0]       ret_lo,
  input logic [PTR_W-1:0] cwp,
  input logic [PTR_W-1:0] cansave,
  input logic [PTR_W-1:0] canrestore,
  input logic [PTR_W-1:0] cleanwin,
  input logic             trap_valid,
  input logic [1:0]       trap_kind
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWIN - 1);

  // R2
  spill_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2'd0 && cansave == '0 |=> trap_valid && trap_kind == 2'd0);

  // R4
  clean_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2'd0 && cansave != '0 && cleanwin == canrestore
    |=> trap_valid && trap_kind == 2'd2);

  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2'd0 && cansave != '0 && cleanwin != canrestore
    |=> !trap_valid && cansave == $past(cansave) - 1'b1
        && cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1));

  // R6 and R8
  fill_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 2'd1 || op_code == 2'd2) && canrestore == '0
    |=> trap_valid && trap_kind == 2'd1);

  // R9
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2'd2 && canrestore != '0 && ret_lo != 2'b00
    |=> trap_valid && trap_kind == 2'd3);

  // R10
  freeze_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $stable(cwp) && $stable(cansave) && $stable(canrestore));

  // R11
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 2'd3 |=> !trap_valid && $stable(cwp));

endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NWIN(NWIN), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .ret_lo     (ret_target[1:0]),
  .cwp        (cwp),
  .cansave    (cansave),
  .canrestore (canrestore),
  .cleanwin   (cleanwin),
  .trap_valid (trap_valid),
  .trap_kind  (trap_kind)
);

// File: tb/regwin_ctrl_test.sv
module regwin_ctrl_test;

  localparam int NWIN   = 8;
  localparam int ADDR_W = 32;
  localparam int PTR_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              op_valid;
  logic [1:0]        op_code;
  logic [ADDR_W-1:0] ret_target;
  logic              ld_valid;
  logic [2:0]        ld_sel;
  logic [5:0]        ld_data;
  logic [PTR_W-1:0]  cwp, cansave, canrestore, cleanwin, otherwin;
  logic [5:0]        wstate;
  logic              trap_valid;
  logic [1:0]        trap_kind;
  logic [4:0]        trap_type;

  always #4 clk = ~clk;

  regwin_ctrl #(.NWIN(NWIN), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ret_target(ret_target), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_data(ld_data), .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_type(trap_type)
  );

  typedef struct {
    int    due;
    bit    tv;
    int    kind;
    int    ttype;
    int    e_cwp;
    int    e_cs;
    int    e_cr;
    string req;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_cwp, m_cs, m_cr, m_cw, m_ow, m_ws;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compare in the cycle each result is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.due == cyc, e.req, "due cycle", cyc, e.due);
      check(trap_valid == e.tv, e.req, "trap_valid", int'(trap_valid), int'(e.tv));
      if (e.tv) begin
        check(int'(trap_kind) == e.kind, e.req, "trap_kind", int'(trap_kind), e.kind);
        check(int'(trap_type) == e.ttype, e.req, "trap_type", int'(trap_type), e.ttype);
      end
      // R10: with a trap these are the unchanged values
      check(int'(cwp) == e.e_cwp, e.req, "cwp", int'(cwp), e.e_cwp);
      check(int'(cansave) == e.e_cs, e.req, "cansave", int'(cansave), e.e_cs);
      check(int'(canrestore) == e.e_cr, e.req, "canrestore", int'(canrestore), e.e_cr);
    end
  end

  // Driver: drives one request and pushes the expected result
  task automatic do_op(input int op, input int tgt, input string req);
    exp_t e;
    int fld;
    @(negedge clk);
    ld_valid   = 1'b0;
    op_valid   = 1'b1;
    op_code    = 2'(op);
    ret_target = ADDR_W'(tgt);
    fld = (m_ow != 0) ? ((m_ws >> 3) & 7) : (m_ws & 7);
    e.due = cyc + 1; e.tv = 0; e.kind = 0; e.ttype = 0; e.req = req;
    if (op == 0) begin
      if (m_cs == 0) begin
        e.tv = 1; e.kind = 0; e.ttype = 4 * fld;
      end else if (((m_cw - m_cr) & (NWIN - 1)) == 0) begin
        e.tv = 1; e.kind = 2;
      end else begin
        m_cwp = (m_cwp + 1) % NWIN;
        m_cs  = m_cs - 1;
        m_cr  = m_cr + 1;
      end
    end else if (op == 1 || op == 2) begin
      if (m_cr == 0) begin
        e.tv = 1; e.kind = 1; e.ttype = 4 * fld;
      end else if (op == 2 && (tgt & 3) != 0) begin
        e.tv = 1; e.kind = 3;
      end else begin
        m_cwp = (m_cwp + NWIN - 1) % NWIN;
        m_cs  = m_cs + 1;
        m_cr  = m_cr - 1;
      end
    end
    e.e_cwp = m_cwp; e.e_cs = m_cs; e.e_cr = m_cr;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    ld_valid = 1'b0;
  endtask

  // R12: load one register, check it one cycle later
  task automatic ld(input int sel, input int val);
    int act;
    @(negedge clk);
    op_valid = 1'b0;
    ld_valid = 1'b1;
    ld_sel   = 3'(sel);
    ld_data  = 6'(val);
    case (sel)
      0: m_cwp = val & (NWIN - 1);
      1: m_cs  = val & (NWIN - 1);
      2: m_cr  = val & (NWIN - 1);
      3: m_cw  = val & (NWIN - 1);
      4: m_ow  = val & (NWIN - 1);
      default: m_ws = val & 63;
    endcase
    @(negedge clk);
    ld_valid = 1'b0;
    case (sel)
      0: begin act = int'(cwp);        check(act == m_cwp, "R12", "load cwp", act, m_cwp); end
      1: begin act = int'(cansave);    check(act == m_cs, "R12", "load cansave", act, m_cs); end
      2: begin act = int'(canrestore); check(act == m_cr, "R12", "load canrestore", act, m_cr); end
      3: begin act = int'(cleanwin);   check(act == m_cw, "R12", "load cleanwin", act, m_cw); end
      4: begin act = int'(otherwin);   check(act == m_ow, "R12", "load otherwin", act, m_ow); end
      default: begin act = int'(wstate); check(act == m_ws, "R12", "load wstate", act, m_ws); end
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'd0; ret_target = '0;
    ld_valid = 1'b0; ld_sel = 3'd0; ld_data = 6'd0;
    m_cwp = 0; m_cs = NWIN - 2; m_cr = 0; m_cw = NWIN - 2; m_ow = 0; m_ws = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(cwp == 0, "R1", "cwp", int'(cwp), 0);
    check(int'(cansave) == NWIN - 2, "R1", "cansave", int'(cansave), NWIN - 2);
    check(canrestore == 0, "R1", "canrestore", int'(canrestore), 0);
    check(int'(cleanwin) == NWIN - 2, "R1", "cleanwin", int'(cleanwin), NWIN - 2);
    check(otherwin == 0, "R1", "otherwin", int'(otherwin), 0);
    check(wstate == 0, "R1", "wstate", int'(wstate), 0);
    check(trap_valid == 0, "R1", "trap_valid", int'(trap_valid), 0);

    // R6 fill at reset, then R3 field choice by otherwin
    do_op(1, 0, "R6"); idle();
    ld(5, 6'b101_011);
    do_op(1, 0, "R3 fill normal"); idle();
    ld(4, 2);
    do_op(2, 0, "R3 fill other"); idle();
    ld(4, 0);

    // R5 saves until full, then R2 spill
    for (int i = 0; i < 6; i++) do_op(0, 0, "R5");
    do_op(0, 0, "R2"); idle();
    ld(4, 1);
    do_op(0, 0, "R3 spill other"); idle();
    ld(4, 0);

    // R7 restores and returns back down
    for (int i = 0; i < 6; i++) do_op((i % 2) + 1, 32'h100 + 4 * i, "R7");
    idle();

    // R5 and R7 pointer wrap at both ends
    ld(0, 7);
    do_op(0, 0, "R5 wrap up");
    do_op(1, 0, "R7 wrap down"); idle();
    ld(0, 0);
    ld(2, 1);
    do_op(2, 32'h40, "R7 return wrap"); idle();

    // R4 clean-window, state frozen (R10)
    ld(1, 3); ld(2, 4); ld(3, 4);
    do_op(0, 0, "R4 R10"); idle();

    // R8 fill beats misalignment; R9 misaligned return
    ld(2, 0);
    do_op(2, 3, "R8"); idle();
    ld(2, 2);
    do_op(2, 5, "R9 R10"); idle();

    // R11 restore ignores target; reserved op does nothing
    do_op(1, 7, "R11 restore target"); idle();
    do_op(3, 1, "R11 reserved"); idle();

    // R12 load dropped when an operation is present
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'd3; ld_valid = 1'b1; ld_sel = 3'd3; ld_data = 6'd1;
    @(negedge clk);
    op_valid = 1'b0; ld_valid = 1'b0;
    check(int'(cleanwin) == m_cw, "R12", "concurrent load dropped", int'(cleanwin), m_cw);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R5", "pending results", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule